// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit forms the 32-bit memory address of a load or store from up to three terms: a base register, an index register multiplied by a power-of-two scale, and a signed displacement. Any of the terms may be left out, so one adder path covers a plain absolute address, a register-indirect address, base plus offset, scaled index plus offset, and the full base-plus-scaled-index-plus-offset form.

The decode stage presents a request with an operand kind and a small addressing descriptor. The unit reads two ports of an external eight-entry register file through its own read-address outputs, in the same cycle. It returns the result one clock later, qualified by a valid strobe. Requests whose operand is an immediate or a register produce no address: they return a valid strobe with the memory flag low. A request that names the stack pointer as index is refused and flagged as an error.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state of `out_valid`, `out_mem` and `out_err` is 0 and of `out_addr` is 0, whatever the request inputs carry.
- R2: `out_valid` is high in exactly the cycles that follow a clock edge at which `req_valid` was high; with no request, `out_valid`, `out_mem` and `out_err` are low.
- R3: For a memory request (`op_kind` = 0) without error, `out_addr` is base term + index term + displacement term and `out_mem` is 1.
- R4: `disp_size` selects the displacement term: 0 gives zero and ignores `disp`, 1 gives `disp[7:0]` sign-extended, 2 gives `disp[15:0]` sign-extended, 3 gives all 32 bits.
- R5: `scale_code` c multiplies only the index term by 2^c, so codes 0, 1, 2 and 3 give factors 1, 2, 4 and 8.
- R6: With `base_en` = 0 the base term is zero and with `idx_en` = 0 the index term is zero, whatever register the matching select names.
- R7: Register codes 0 to 7 name the eight registers in the order accumulator, counter, data, base, stack pointer, frame pointer, source, destination; `rf_base_raddr` follows `base_sel` and `rf_idx_raddr` follows `idx_sel`, and any code, the stack pointer included, is accepted as base.
- R8: `op_kind` 1 (immediate), 2 (register) and 3 (reserved) produce `out_valid` with `out_mem` = 0, `out_err` = 0 and `out_addr` = 0.
- R9: A memory request with `idx_en` = 1 and `idx_sel` = 4 (stack pointer) gives `out_err` = 1, `out_mem` = 0 and `out_addr` = 0; with `idx_en` = 0 the same select raises no error.
- R10: The sum wraps modulo 2^32 with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| op_kind | input | 2 | 0 memory, 1 immediate, 2 register, 3 reserved |
| base_en | input | 1 | Base term present |
| base_sel | input | 3 | Base register code |
| idx_en | input | 1 | Index term present |
| idx_sel | input | 3 | Index register code |
| scale_code | input | 2 | Index shift amount |
| disp_size | input | 2 | 0 none, 1 byte, 2 half-word, 3 word |
| disp | input | 32 | Displacement field, right-aligned |
| rf_base_raddr | output | 3 | Register file read address for the base |
| rf_base_rdata | input | 32 | Register file read data for the base |
| rf_idx_raddr | output | 3 | Register file read address for the index |
| rf_idx_rdata | input | 32 | Register file read data for the index |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_mem | output | 1 | An address was produced |
| out_err | output | 1 | Stack pointer requested as index |
| out_addr | output | 32 | Effective address |

## Verification
The bench targets the sign bit of short displacements (0x80 and 0x8000), where a zero-extending design would land 256 or 65536 bytes too high, and a `disp_size` of 0 with garbage in `disp`, which a design adding the raw field would pass straight into the address. It drives the stack pointer as index and as base, so a design that refuses the wrong one, or adds the index anyway, is caught, and it uses scale code 3 and index-only forms so that a scale misapplied to the base shows up. Sums that carry out of bit 31 check the wrap, and back-to-back requests mixed with immediate and register kinds expose a stale address or a missing strobe.

// File: rtl/ea_pkg.sv
// Shared encodings for the effective address generator.
// Assumes a flat 32-bit address space and an eight-entry register file.
package ea_pkg;
    localparam int ADDR_W  = 32;
    localparam int NUM_REG = 8;
    localparam int SEL_W   = $clog2(NUM_REG);

    typedef enum logic [1:0] {
        KIND_MEM = 2'd0,
        KIND_IMM = 2'd1,
        KIND_REG = 2'd2,
        KIND_RSV = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        DSZ_NONE = 2'd0,
        DSZ_B8   = 2'd1,
        DSZ_B16  = 2'd2,
        DSZ_B32  = 2'd3
    } disp_size_e;

    // Register code of the stack pointer, which may not act as index.
    localparam logic [SEL_W-1:0] SP_CODE = SEL_W'(4);
endpackage

// File: rtl/ea_disp_ext.sv
// Displacement widener: picks the active low bits of the displacement
// field and sign-extends them to the address width.
// Assumes the field is right-aligned and unused upper bits are junk.
module ea_disp_ext #(
    parameter int W = 32
) (
    input  logic [1:0]   size,
    input  logic [W-1:0] raw,
    output logic [W-1:0] ext
);
    localparam int B8  = 8;
    localparam int B16 = 16;

    // Select and sign-extend by size code.
    always_comb begin
        unique case (size)
            ea_pkg::DSZ_NONE: ext = '0;
            ea_pkg::DSZ_B8:   ext = {{(W-B8){raw[B8-1]}}, raw[B8-1:0]};
            ea_pkg::DSZ_B16:  ext = {{(W-B16){raw[B16-1]}}, raw[B16-1:0]};
            default:          ext = raw;
        endcase
    end
endmodule

// File: rtl/ea_index_scale.sv
// Index term former: gates the index register value and shifts it left
// by the scale code. Assumes scale codes are shift amounts (x1..x8).
module ea_index_scale #(
    parameter int W   = 32,
    parameter int SCW = 2
) (
    input  logic           en,
    input  logic [W-1:0]   idx,
    input  logic [SCW-1:0] sc,
    output logic [W-1:0]   term
);
    // Shift-left mux, one stage per scale bit.
    logic [W-1:0] stage [SCW+1];
    assign stage[0] = en ? idx : '0;

    for (genvar g = 0; g < SCW; g++) begin : g_shift
        assign stage[g+1] = sc[g] ? (stage[g] << (1 << g)) : stage[g];
    end

    assign term = stage[SCW];
endmodule

// File: rtl/ea_sum.sv
// Multi-operand modular adder. Terms are packed side by side; the
// result wraps at W bits with no carry-out. Assumes N is small.
module ea_sum #(
    parameter int W = 32,
    parameter int N = 3
) (
    input  logic [N*W-1:0] terms,
    output logic [W-1:0]   sum
);
    // Accumulate every term into one wrapped sum.
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) begin
            sum = sum + terms[i*W +: W];
        end
    end
endmodule

// File: rtl/ea_gen.sv
// Effective address generator top. Reads base and index from an external
// register file in the request cycle, forms base + index*2^scale + disp
// and registers the result one cycle later with a valid strobe.
// Assumes register file reads are combinational and ready in-cycle.
module ea_gen #(
    parameter int AW  = ea_pkg::ADDR_W,
    parameter int NR  = ea_pkg::NUM_REG,
    parameter int SCW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            op_kind,
    input  logic                  base_en,
    input  logic [$clog2(NR)-1:0] base_sel,
    input  logic                  idx_en,
    input  logic [$clog2(NR)-1:0] idx_sel,
    input  logic [SCW-1:0]        scale_code,
    input  logic [1:0]            disp_size,
    input  logic [AW-1:0]         disp,
    output logic [$clog2(NR)-1:0] rf_base_raddr,
    input  logic [AW-1:0]         rf_base_rdata,
    output logic [$clog2(NR)-1:0] rf_idx_raddr,
    input  logic [AW-1:0]         rf_idx_rdata,
    output logic                  out_valid,
    output logic                  out_mem,
    output logic                  out_err,
    output logic [AW-1:0]         out_addr
);
    localparam int SW     = $clog2(NR);
    localparam int NTERMS = 3;
    localparam logic [SW-1:0] SP_SEL = SW'(ea_pkg::SP_CODE);

    logic [AW-1:0] base_term;
    logic [AW-1:0] idx_term;
    logic [AW-1:0] disp_term;
    logic [AW-1:0] sum_addr;
    logic          is_mem;
    logic          bad_idx;

    // Register file read ports follow the selects directly.
    assign rf_base_raddr = base_sel;
    assign rf_idx_raddr  = idx_sel;

    // Base term is zero when the base is absent.
    assign base_term = base_en ? rf_base_rdata : '0;

    ea_index_scale #(.W(AW), .SCW(SCW)) u_scale (
        .en   (idx_en),
        .idx  (rf_idx_rdata),
        .sc   (scale_code),
        .term (idx_term)
    );

    ea_disp_ext #(.W(AW)) u_disp (
        .size (disp_size),
        .raw  (disp),
        .ext  (disp_term)
    );

    ea_sum #(.W(AW), .N(NTERMS)) u_sum (
        .terms ({disp_term, idx_term, base_term}),
        .sum   (sum_addr)
    );

    // Classify the request: memory kind, and illegal stack-pointer index.
    assign is_mem  = (op_kind == ea_pkg::KIND_MEM);
    assign bad_idx = is_mem && idx_en && (idx_sel == SP_SEL);

    // Output register: one-cycle latency, zeroed when idle or not an address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mem   <= 1'b0;
            out_err   <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= req_valid;
            out_mem   <= req_valid && is_mem && !bad_idx;
            out_err   <= req_valid && bad_idx;
            out_addr  <= (req_valid && is_mem && !bad_idx) ? sum_addr : '0;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !out_mem && !out_err)); // R2
    AST_NONMEM_NOADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_kind != 2'd0) |=> (!out_mem && !out_err && out_addr == '0)); // R8
    AST_SP_INDEX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_kind == 2'd0 && idx_en && idx_sel == SP_SEL)
            |=> (out_err && !out_mem && out_addr == '0)); // R9
    AST_NO_INDEX_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !idx_en) |=> !out_err); // R9
    AST_MEM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_kind == 2'd0 && !(idx_en && idx_sel == SP_SEL)
         && !base_en && !idx_en && disp_size == 2'd3)
            |=> (out_mem && out_addr == $past(disp))); // R3
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_err && out_mem)); // R9
    AST_RF_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_base_raddr == base_sel) && (rf_idx_raddr == idx_sel)); // R7
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  op_kind = '0;
    logic        base_en = 1'b0;
    logic [2:0]  base_sel = '0;
    logic        idx_en = 1'b0;
    logic [2:0]  idx_sel = '0;
    logic [1:0]  scale_code = '0;
    logic [1:0]  disp_size = '0;
    logic [31:0] disp = '0;
    logic [2:0]  rf_base_raddr, rf_idx_raddr;
    logic [31:0] rf_base_rdata, rf_idx_rdata;
    logic        out_valid, out_mem, out_err;
    logic [31:0] out_addr;

    logic [31:0] regs [8];

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic        e_valid = 1'b0, e_mem = 1'b0, e_err = 1'b0;
    logic [31:0] e_addr = '0;
    string       e_tag = "R1";

    always #(CLK_NS/2) clk = ~clk;

    assign rf_base_rdata = regs[rf_base_raddr];
    assign rf_idx_rdata  = regs[rf_idx_raddr];

    ea_gen u_ea_gen (
        .clk, .rst_n, .req_valid, .op_kind, .base_en, .base_sel,
        .idx_en, .idx_sel, .scale_code, .disp_size, .disp,
        .rf_base_raddr, .rf_base_rdata, .rf_idx_raddr, .rf_idx_rdata,
        .out_valid, .out_mem, .out_err, .out_addr
    );

    task automatic check_out();
        n_checks++;
        if (out_valid !== e_valid || out_mem !== e_mem ||
            out_err !== e_err || out_addr !== e_addr) begin
            n_fail++;
            $display("FAIL %s: got v=%b m=%b e=%b a=%h, expected v=%b m=%b e=%b a=%h",
                     e_tag, out_valid, out_mem, out_err, out_addr,
                     e_valid, e_mem, e_err, e_addr);
        end
    endtask

    // Behavioural reference for one request.
    task automatic predict(string tag);
        longint unsigned acc;
        logic [31:0] d;
        e_tag = tag;
        e_valid = 1'b1;
        e_mem = 1'b0;
        e_err = 1'b0;
        e_addr = '0;
        if (op_kind != 2'd0) return;
        if (idx_en && idx_sel == 3'd4) begin
            e_err = 1'b1;
            return;
        end
        case (disp_size)
            2'd0: d = 32'd0;
            2'd1: d = 32'($signed(disp[7:0]));
            2'd2: d = 32'($signed(disp[15:0]));
            default: d = disp;
        endcase
        acc = 0;
        if (base_en) acc += regs[base_sel];
        if (idx_en) acc += longint'(regs[idx_sel]) * (longint'(1) << scale_code);
        acc += d;
        e_mem = 1'b1;
        e_addr = acc[31:0];
    endtask

    task automatic req(string tag, logic [1:0] k, logic be, logic [2:0] bs,
                       logic ie, logic [2:0] is, logic [1:0] sc,
                       logic [1:0] ds, logic [31:0] d);
        @(negedge clk);
        check_out();
        req_valid = 1'b1; op_kind = k; base_en = be; base_sel = bs;
        idx_en = ie; idx_sel = is; scale_code = sc; disp_size = ds; disp = d;
        predict(tag);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        check_out();
        req_valid = 1'b0; op_kind = 2'd0; base_en = 1'b1; idx_en = 1'b1;
        idx_sel = 3'd4; disp = 32'hFFFF_FFFF;
        e_tag = tag; e_valid = 1'b0; e_mem = 1'b0; e_err = 1'b0; e_addr = '0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
    end

    initial begin
        regs[0] = 32'h0000_1000; regs[1] = 32'h0000_0020;
        regs[2] = 32'hFFFF_FFF0; regs[3] = 32'h0000_0007;
        regs[4] = 32'h0000_8000; regs[5] = 32'h1234_5678;
        regs[6] = 32'h0000_0003; regs[7] = 32'hFFFF_FFFF;
        // R1: request held high during reset must not reach the outputs.
        req_valid = 1'b1; base_en = 1'b1; disp_size = 2'd3; disp = 32'h55;
        repeat (3) begin
            @(negedge clk);
            check_out();
        end
        rst_n = 1'b1;
        req_valid = 1'b0;
        idle("R2");
        // R3 / R4: absolute address, full displacement.
        req("R4", 2'd0, 0, 3'd0, 0, 3'd0, 2'd0, 2'd3, 32'hCAFE_0010);
        // R7 / R6: base only, each register code, junk disp ignored.
        for (int r = 0; r < 8; r++)
            req("R7", 2'd0, 1, 3'(r), 0, 3'd4, 2'd3, 2'd0, 32'hDEAD_BEEF);
        // R4: byte displacement, both signs.
        req("R4", 2'd0, 1, 3'd0, 0, 3'd0, 2'd0, 2'd1, 32'h0000_0080);
        req("R4", 2'd0, 1, 3'd0, 0, 3'd0, 2'd0, 2'd1, 32'hFFFF_FF7F);
        // R4: half-word displacement, both signs.
        req("R4", 2'd0, 1, 3'd1, 0, 3'd0, 2'd0, 2'd2, 32'h1234_8000);
        req("R4", 2'd0, 1, 3'd1, 0, 3'd0, 2'd0, 2'd2, 32'hABCD_7FFF);
        // R5: scaled index plus displacement, every scale code.
        for (int s = 0; s < 4; s++)
            req("R5", 2'd0, 0, 3'd5, 1, 3'd6, 2'(s), 2'd1, 32'h0000_0004);
        // R3: full form with scale 8.
        req("R3", 2'd0, 1, 3'd0, 1, 3'd3, 2'd3, 2'd2, 32'h0000_FFFE);
        // R6: index absent, select names stack pointer: no error.
        req("R6", 2'd0, 1, 3'd5, 0, 3'd4, 2'd3, 2'd0, 32'd0);
        // R9: stack pointer as index is refused; as base it is fine.
        req("R9", 2'd0, 1, 3'd0, 1, 3'd4, 2'd1, 2'd3, 32'h10);
        req("R9", 2'd0, 1, 3'd4, 1, 3'd1, 2'd0, 2'd0, 32'd0);
        // R8: immediate, register and reserved kinds give no address.
        req("R8", 2'd1, 1, 3'd5, 1, 3'd6, 2'd2, 2'd3, 32'h1111_1111);
        req("R8", 2'd2, 1, 3'd0, 0, 3'd0, 2'd0, 2'd3, 32'h2222_2222);
        req("R8", 2'd3, 1, 3'd7, 1, 3'd4, 2'd0, 2'd0, 32'd0);
        // R10: wrap-around past bit 31.
        req("R10", 2'd0, 1, 3'd7, 1, 3'd7, 2'd3, 2'd3, 32'hF000_0000);
        req("R10", 2'd0, 1, 3'd2, 0, 3'd0, 2'd0, 2'd1, 32'h0000_0020);
        idle("R2");
        idle("R2");
        // R3: mixed traffic with gaps.
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 4) == 0) idle("R2");
            else req("R3", 2'($urandom_range(0, 5) > 3 ? $urandom_range(1, 3) : 0),
                     1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom),
                     2'($urandom), 2'($urandom), 32'($urandom));
        end
        idle("R2");
        @(negedge clk);
        check_out();
        summary();
    end
endmodule